// File: doc/BRIEF.md
# Key Snapshot Ghost Filter and Event Differ

This block sits behind a keyboard matrix scanner. Each time the scanner finishes a pass it presents one snapshot: up to eight entries, each a 7-bit scan code (matrix row in the upper four bits, column in the lower three) with its own valid bit. Alternatively, the scanner can flag that every key is up. The block first removes an optional function-modifier key. When that key is present, the block moves every other key of the snapshot into an upper layer by adding the full matrix key count (128). It then rejects snapshots that show the electrical ghosting pattern of a passive matrix. Finally it compares the accepted key set against the set it holds from the previous accepted snapshot.

For an accepted snapshot the block emits a stream of event records on a valid/ready output. First come releases for held keys that have vanished. Then come presses for every key of the new set. A sync record closes the group. The held set is then replaced. A rejected snapshot produces nothing and changes nothing. The function-key code and the two mode enables are configuration inputs that are expected to stay static while a snapshot is being processed.

Top module: `keyset_diff`

## Requirements
- R1: A scan code is (row << 3) | column, with the row in bits [6:3] and the column in bits [2:0]. An event code is 8 bits, and bit 7 marks the function layer.
- R2: The ghost test is applied only when `cfg_ghost_en` is 1 and the snapshot holds at least three reported keys. The count is taken after a swallowed function key has been removed.
- R3: A snapshot is rejected when some pair of its keys shares a row and some pair (not necessarily the same pair) shares a column. A rejected snapshot emits no event and leaves the held set unchanged.
- R4: With `cfg_layer_en` at 1, an entry equal to `cfg_fn_code` is not reported, and each other key of that snapshot gets 128 added to its code. With `cfg_layer_en` at 0, that code is an ordinary key.
- R5: For an accepted snapshot, each held key that is absent from the new set produces one release record (press flag 0), in held order.
- R6: Every key of an accepted snapshot produces one press record (press flag 1), in slot order. All releases come before the first press.
- R7: Each accepted snapshot ends with exactly one sync record: `ev_sync` is 1, the code is 0 and the press flag is 0.
- R8: After an accepted snapshot, the held set and its count are exactly the new set.
- R9: A snapshot with `snap_all_up` at 1 ignores its entries. It releases every held key, sends a sync record and leaves the held set empty.
- R10: An offered record keeps its fields stable until `ev_ready` takes it. While `snap_ready` is 0, a `snap_valid` strobe is ignored.
- R11: After reset, `ev_valid` is 0, `snap_ready` is 1 and the held set is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ghost_en | input | 1 | Enable the ghost rejection test |
| cfg_layer_en | input | 1 | Enable function-key removal and layer offset |
| cfg_fn_code | input | 7 | Scan code of the function key |
| snap_valid | input | 1 | Snapshot strobe, taken when snap_ready is 1 |
| snap_ready | output | 1 | Block idle and able to take a snapshot |
| snap_all_up | input | 1 | Snapshot means every key released |
| snap_mask | input | 8 | Valid bit per entry slot |
| snap_codes | input | 56 | Eight 7-bit scan codes, slot 0 in bits [6:0] |
| ev_valid | output | 1 | Event record offered |
| ev_ready | input | 1 | Consumer takes the record |
| ev_code | output | 8 | Event scan code including layer bit |
| ev_press | output | 1 | 1 for press, 0 for release or sync |
| ev_sync | output | 1 | Record closes a snapshot |

## Verification
The bench targets three kinds of ghost cases. In the first, the row pair and the column pair are different pairs; a design that demands one key sharing both would accept that snapshot. In the second, the function key is what creates the shared row and column; a design that counts keys before removing it would wrongly reject the snapshot. In the third, the filter is disabled; a design that ignores the enable would reject it. A snapshot after each rejection proves, through its release records, that the held set survived. A design that updated state on rejection would emit the wrong releases there. Further cases are the layer offset and its removal, the all-up flag with full and empty held sets, a full eight-key snapshot, a strobe arriving while busy, and output back-pressure. Each would show up as a wrong, missing or extra record in the compared stream.

// File: rtl/keyset_pkg.sv
package keyset_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_REL  = 2'd1,
    PH_PRS  = 2'd2,
    PH_SYNC = 2'd3
  } phase_t;
endpackage

// File: rtl/keyset_prep.sv
// Function-key removal, compaction, layer offset and ghost test for one snapshot.
module keyset_prep #(
  parameter int SLOTS = 8,
  parameter int ROW_W = 4,
  parameter int COL_W = 3,
  localparam int KEY_W = ROW_W + COL_W,
  localparam int EV_W  = KEY_W + 1,
  localparam int CNT_W = $clog2(SLOTS + 1),
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic                   layer_en,
  input  logic                   ghost_en,
  input  logic [KEY_W-1:0]       fn_code,
  input  logic [SLOTS-1:0]       mask,
  input  logic [SLOTS*KEY_W-1:0] codes,
  output logic [EV_W-1:0]        list_o [SLOTS],
  output logic [CNT_W-1:0]       cnt_o,
  output logic                   ghost_o
);
  logic [KEY_W-1:0] raw [SLOTS];
  logic [SLOTS-1:0] keep;
  logic             fn_hit;
  logic [CNT_W-1:0] pos;
  logic             row_hit, col_hit;

  for (genvar g = 0; g < SLOTS; g++) begin : g_unpack
    assign raw[g] = codes[g*KEY_W +: KEY_W];
  end

  // R4: swallow the function key and note its presence
  always_comb begin
    keep   = '0;
    fn_hit = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (mask[i]) begin
        if (layer_en && raw[i] == fn_code) fn_hit = 1'b1;
        else                               keep[i] = 1'b1;
      end
    end
  end

  // compaction in slot order; layer offset equals the matrix key count (MSB)
  always_comb begin
    pos = '0;
    for (int i = 0; i < SLOTS; i++) list_o[i] = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (keep[i]) begin
        list_o[pos[IDX_W-1:0]] = {fn_hit, raw[i]};
        pos = pos + 1'b1;
      end
    end
  end

  // R3: any row-sharing pair together with any column-sharing pair
  always_comb begin
    row_hit = 1'b0;
    col_hit = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      for (int j = i + 1; j < SLOTS; j++) begin
        if (keep[i] && keep[j]) begin
          if (raw[i][KEY_W-1:COL_W] == raw[j][KEY_W-1:COL_W]) row_hit = 1'b1;
          if (raw[i][COL_W-1:0] == raw[j][COL_W-1:0])         col_hit = 1'b1;
        end
      end
    end
  end

  assign cnt_o   = pos;
  assign ghost_o = ghost_en && (pos >= CNT_W'(3)) && row_hit && col_hit;
endmodule

// File: rtl/keyset_member.sv
// Tells whether a probe code is present among the first cnt entries of a set.
module keyset_member #(
  parameter int SLOTS = 8,
  parameter int EV_W  = 8,
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic [EV_W-1:0]  probe,
  input  logic [EV_W-1:0]  set_i [SLOTS],
  input  logic [CNT_W-1:0] cnt,
  output logic             hit
);
  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (CNT_W'(i) < cnt && set_i[i] == probe) hit = 1'b1;
    end
  end
endmodule

// File: rtl/keyset_diff.sv
module keyset_diff #(
  parameter int SLOTS = 8,
  parameter int ROW_W = 4,
  parameter int COL_W = 3,
  localparam int KEY_W = ROW_W + COL_W,
  localparam int EV_W  = KEY_W + 1,
  localparam int CNT_W = $clog2(SLOTS + 1),
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_ghost_en,
  input  logic                   cfg_layer_en,
  input  logic [KEY_W-1:0]       cfg_fn_code,
  input  logic                   snap_valid,
  output logic                   snap_ready,
  input  logic                   snap_all_up,
  input  logic [SLOTS-1:0]       snap_mask,
  input  logic [SLOTS*KEY_W-1:0] snap_codes,
  output logic                   ev_valid,
  input  logic                   ev_ready,
  output logic [EV_W-1:0]        ev_code,
  output logic                   ev_press,
  output logic                   ev_sync
);
  import keyset_pkg::*;

  phase_t           phase;
  logic [CNT_W-1:0] idx;
  logic [EV_W-1:0]  held [SLOTS];
  logic [CNT_W-1:0] held_cnt;
  logic [EV_W-1:0]  nxt [SLOTS];
  logic [CNT_W-1:0] nxt_cnt;

  logic [EV_W-1:0]  prep_list [SLOTS];
  logic [CNT_W-1:0] prep_cnt;
  logic             prep_ghost;
  logic             in_new;
  logic             slot_free;

  keyset_prep #(.SLOTS(SLOTS), .ROW_W(ROW_W), .COL_W(COL_W)) u_prep (
    .layer_en (cfg_layer_en),
    .ghost_en (cfg_ghost_en),
    .fn_code  (cfg_fn_code),
    .mask     (snap_mask),
    .codes    (snap_codes),
    .list_o   (prep_list),
    .cnt_o    (prep_cnt),
    .ghost_o  (prep_ghost)
  );

  keyset_member #(.SLOTS(SLOTS), .EV_W(EV_W)) u_member (
    .probe (held[idx[IDX_W-1:0]]),
    .set_i (nxt),
    .cnt   (nxt_cnt),
    .hit   (in_new)
  );

  assign slot_free  = !ev_valid || ev_ready;
  assign snap_ready = (phase == PH_IDLE) && !ev_valid;

  // set storage: plain register arrays, no reset (only counts are reset)
  always_ff @(posedge clk) begin
    if (phase == PH_IDLE && snap_ready && snap_valid) nxt <= prep_list;
    if (phase == PH_SYNC && slot_free)                held <= nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      idx      <= '0;
      held_cnt <= '0;
      nxt_cnt  <= '0;
      ev_valid <= 1'b0;
      ev_code  <= '0;
      ev_press <= 1'b0;
      ev_sync  <= 1'b0;
    end else begin
      if (ev_valid && ev_ready) ev_valid <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (snap_ready && snap_valid && (snap_all_up || !prep_ghost)) begin
            nxt_cnt <= snap_all_up ? '0 : prep_cnt;
            idx     <= '0;
            phase   <= PH_REL;
          end
        end
        PH_REL: begin
          if (slot_free) begin
            if (idx >= held_cnt) begin
              idx   <= '0;
              phase <= PH_PRS;
            end else begin
              if (!in_new) begin
                ev_valid <= 1'b1;
                ev_code  <= held[idx[IDX_W-1:0]];
                ev_press <= 1'b0;
                ev_sync  <= 1'b0;
              end
              idx <= idx + 1'b1;
            end
          end
        end
        PH_PRS: begin
          if (slot_free) begin
            if (idx >= nxt_cnt) begin
              phase <= PH_SYNC;
            end else begin
              ev_valid <= 1'b1;
              ev_code  <= nxt[idx[IDX_W-1:0]];
              ev_press <= 1'b1;
              ev_sync  <= 1'b0;
              idx      <= idx + 1'b1;
            end
          end
        end
        PH_SYNC: begin
          if (slot_free) begin
            ev_valid <= 1'b1;
            ev_code  <= '0;
            ev_press <= 1'b0;
            ev_sync  <= 1'b1;
            held_cnt <= nxt_cnt;
            phase    <= PH_IDLE;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/keyset_diff_chk.sv
module keyset_diff_chk #(
  parameter int EV_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            snap_valid,
  input logic            snap_ready,
  input logic            snap_all_up,
  input logic            ev_valid,
  input logic            ev_ready,
  input logic [EV_W-1:0] ev_code,
  input logic            ev_press,
  input logic            ev_sync
);
  logic seen_press;
  logic all_up_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_press <= 1'b0;
      all_up_run <= 1'b0;
    end else begin
      if (snap_valid && snap_ready && snap_all_up) all_up_run <= 1'b1;
      if (ev_valid && ev_ready) begin
        if (ev_sync) begin
          seen_press <= 1'b0;
          all_up_run <= 1'b0;
        end else if (ev_press) begin
          seen_press <= 1'b1;
        end
      end
    end
  end

  // R10
  ev_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ev_valid && !ev_ready |=> ev_valid && $stable(ev_code) && $stable(ev_press) && $stable(ev_sync));

  // R7
  sync_clean_chk: assert property (@(posedge clk) disable iff (rst)
    ev_valid && ev_sync |-> ev_code == '0 && !ev_press);

  // R6
  rel_before_prs_chk: assert property (@(posedge clk) disable iff (rst)
    ev_valid && seen_press |-> ev_press || ev_sync);

  // R9
  all_up_no_press_chk: assert property (@(posedge clk) disable iff (rst)
    ev_valid && all_up_run |-> !ev_press);

  // R11
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !ev_valid && snap_ready);
endmodule

bind keyset_diff keyset_diff_chk #(.EV_W(EV_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .snap_valid  (snap_valid),
  .snap_ready  (snap_ready),
  .snap_all_up (snap_all_up),
  .ev_valid    (ev_valid),
  .ev_ready    (ev_ready),
  .ev_code     (ev_code),
  .ev_press    (ev_press),
  .ev_sync     (ev_sync)
);

// File: tb/keyset_diff_test.sv
`timescale 1ns/1ps
module keyset_diff_test;
  localparam int FN = 7;  // function key: row 0, column 7

  typedef struct packed {
    logic        all_up;
    logic        ghost_en;
    logic        layer_en;
    logic [7:0]  mask;
    logic [55:0] codes;
  } vec_t;

  function automatic logic [55:0] c8(input logic [6:0] a0, a1, a2, a3, a4, a5, a6, a7);
    return {a7, a6, a5, a4, a3, a2, a1, a0};
  endfunction

  localparam vec_t VECS [11] = '{
    '{1'b0, 1'b1, 1'b0, 8'h07, c8(7'h11, 7'h22, 7'h33, 0, 0, 0, 0, 0)},
    '{1'b0, 1'b1, 1'b0, 8'h03, c8(7'h11, 7'h40, 0, 0, 0, 0, 0, 0)},
    '{1'b0, 1'b1, 1'b0, 8'h07, c8(7'h11, 7'h14, 7'h24, 0, 0, 0, 0, 0)},
    '{1'b0, 1'b1, 1'b0, 8'h0F, c8(7'h11, 7'h15, 7'h23, 7'h33, 0, 0, 0, 0)},
    '{1'b0, 1'b0, 1'b0, 8'h07, c8(7'h11, 7'h14, 7'h24, 0, 0, 0, 0, 0)},
    '{1'b0, 1'b1, 1'b1, 8'h07, c8(7'h11, 7'h07, 7'h17, 0, 0, 0, 0, 0)},
    '{1'b0, 1'b0, 1'b0, 8'h07, c8(7'h11, 7'h07, 7'h17, 0, 0, 0, 0, 0)},
    '{1'b1, 1'b1, 1'b0, 8'h05, c8(7'h55, 7'h66, 7'h77, 0, 0, 0, 0, 0)},
    '{1'b1, 1'b1, 1'b0, 8'h00, c8(0, 0, 0, 0, 0, 0, 0, 0)},
    '{1'b0, 1'b0, 1'b0, 8'hFF, c8(7'd0, 7'd9, 7'd18, 7'd27, 7'd36, 7'd45, 7'd54, 7'd63)},
    '{1'b0, 1'b1, 1'b0, 8'h00, c8(7'h11, 0, 0, 0, 0, 0, 0, 0)}
  };

  function automatic string vec_tag(input int i);
    case (i)
      0: return "R6 R1 basic press";
      1: return "R5 partial release";
      2: return "R3 ghost same key";
      3: return "R3 ghost split pairs";
      4: return "R2 filter off, R3 state kept";
      5: return "R4 R2 layer and count";
      6: return "R4 layer off";
      7: return "R9 all up";
      8: return "R9 all up empty";
      9: return "R6 eight keys";
      default: return "R5 R8 empty snapshot";
    endcase
  endfunction

  logic        clk = 0;
  logic        rst = 1;
  logic        cfg_ghost_en = 0, cfg_layer_en = 0;
  logic [6:0]  cfg_fn_code = 7'(FN);
  logic        snap_valid = 0, snap_all_up = 0;
  logic [7:0]  snap_mask = 0;
  logic [55:0] snap_codes = 0;
  logic        snap_ready, ev_valid, ev_press, ev_sync;
  logic        ev_ready = 1;
  logic [7:0]  ev_code;

  keyset_diff uut (
    .clk(clk), .rst(rst), .cfg_ghost_en(cfg_ghost_en), .cfg_layer_en(cfg_layer_en),
    .cfg_fn_code(cfg_fn_code), .snap_valid(snap_valid), .snap_ready(snap_ready),
    .snap_all_up(snap_all_up), .snap_mask(snap_mask), .snap_codes(snap_codes),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_code(ev_code),
    .ev_press(ev_press), .ev_sync(ev_sync)
  );

  always #5 clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;
  bit bp_on = 0;
  int got_ev [64];
  int got_n = 0;
  int exp_ev [64];
  int exp_n = 0;
  int m_held [8];
  int m_cnt = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 ev_ready = bp_on ? (cyc % 3 != 1) : 1'b1;
  end

  always @(negedge clk) begin
    if (!rst && ev_valid && ev_ready && got_n < 64) begin
      got_ev[got_n] = {22'd0, ev_sync, ev_press, ev_code};
      got_n = got_n + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  // reference model built from the requirements
  task automatic model(input vec_t v);
    int lst [8];
    int n = 0;
    bit fnh = 0, rh = 0, ch = 0;
    exp_n = 0;
    for (int i = 0; i < 8; i++) begin
      if (v.mask[i]) begin
        int c = int'(v.codes[i*7 +: 7]);
        if (v.layer_en && c == FN) fnh = 1;
        else begin lst[n] = c; n++; end
      end
    end
    for (int i = 0; i < n; i++)
      for (int j = i + 1; j < n; j++) begin
        if ((lst[i] >> 3) == (lst[j] >> 3)) rh = 1;
        if ((lst[i] & 7) == (lst[j] & 7))   ch = 1;
      end
    if (!v.all_up && v.ghost_en && n >= 3 && rh && ch) return;
    if (v.all_up) n = 0;
    else if (fnh) for (int i = 0; i < n; i++) lst[i] += 128;
    for (int i = 0; i < m_cnt; i++) begin
      bit found = 0;
      for (int j = 0; j < n; j++) if (lst[j] == m_held[i]) found = 1;
      if (!found) begin exp_ev[exp_n] = m_held[i]; exp_n++; end
    end
    for (int i = 0; i < n; i++) begin exp_ev[exp_n] = 256 | lst[i]; exp_n++; end
    exp_ev[exp_n] = 512; exp_n++;
    for (int i = 0; i < n; i++) m_held[i] = lst[i];
    m_cnt = n;
  endtask

  task automatic apply(input vec_t v, input string tag, input bit inject);
    int guard = 0;
    got_n = 0;
    model(v);
    @(negedge clk);
    while (!snap_ready && guard < 500) begin @(negedge clk); guard++; end
    cfg_ghost_en = v.ghost_en; cfg_layer_en = v.layer_en;
    snap_all_up = v.all_up; snap_mask = v.mask; snap_codes = v.codes;
    snap_valid = 1;
    @(negedge clk);
    if (inject) begin
      // R10: strobe while busy with a different snapshot
      snap_all_up = 0; snap_mask = 8'h01; snap_codes = c8(7'h55, 0, 0, 0, 0, 0, 0, 0);
    end else snap_valid = 0;
    @(negedge clk);
    snap_valid = 0;
    guard = 0;
    while (!snap_ready && guard < 500) begin @(negedge clk); guard++; end
    @(negedge clk);
    chk(got_n == exp_n, {tag, " event count"}, got_n, exp_n);
    for (int k = 0; k < exp_n && k < got_n; k++)
      chk(got_ev[k] == exp_ev[k], {tag, " event"}, got_ev[k], exp_ev[k]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(snap_ready == 1'b1, "R11 snap_ready after reset", int'(snap_ready), 1);
    chk(ev_valid == 1'b0, "R11 ev_valid after reset", int'(ev_valid), 0);

    for (int i = 0; i < 11; i++) begin
      bp_on = (i >= 5);
      apply(VECS[i], vec_tag(i), 1'b0);
    end

    // R10: busy strobe ignored, then empty snapshot shows held set
    bp_on = 0;
    apply('{1'b0, 1'b1, 1'b0, 8'h03, c8(7'h11, 7'h22, 0, 0, 0, 0, 0, 0)}, "R10 busy strobe", 1'b1);
    apply('{1'b0, 1'b1, 1'b0, 8'h00, c8(0, 0, 0, 0, 0, 0, 0, 0)}, "R10 R8 after busy strobe", 1'b0);

    // R11: reset mid-stream empties the held set
    apply('{1'b0, 1'b1, 1'b0, 8'h01, c8(7'h42, 0, 0, 0, 0, 0, 0, 0)}, "R6 before reset", 1'b0);
    rst = 1;
    @(negedge clk);
    rst = 0;
    m_cnt = 0;
    apply('{1'b0, 1'b1, 1'b0, 8'h01, c8(7'h43, 0, 0, 0, 0, 0, 0, 0)}, "R11 held empty after reset", 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule